// File: doc/BRIEF.md
# Two-Dimensional Block Transfer Address Sequencer

This block produces the address stream for a rectangular memory transfer built from 16-bit elements. Software describes the walk with a base byte address, an element count per row, a signed byte stride between elements, a row count and a signed byte stride that is applied after the final element of each row. Once started, the block presents one address per cycle. A sink or source accepts that address with a ready handshake, and the block holds the address until it is accepted. Moving the data is left to the logic around it.

A contiguous frame scan is described by an element stride of 2 and a row stride of 2. A 24-bit-per-pixel row W pixels wide holds W×3/2 elements. To blit a W-pixel-wide image into a 320-pixel-wide 24 bpp buffer, set the row stride to (320−W)×3+2. The destination base of such a blit is the buffer base plus the X coordinate rounded down to even times 3, plus Y×960. In circular mode the block returns to the base address after the last element of the frame, with no idle cycle, and keeps going until the enable is removed. In single-shot mode it raises a completion flag and falls idle. The completion and fault flags are sticky, and each is cleared by pulsing its own clear input.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, valid, busy, done and err are all low.
- R2: When en is high in idle with done and err low and a legal configuration, the next cycle shows valid and busy high and addr equal to cfg_start. The configuration is captured at that moment.
- R3: Each accepted element (valid and ready both high) that is not the last of its row moves addr by cfg_x_mod, taken as a signed two's complement byte offset.
- R4: Accepting the last element of a row moves addr by cfg_y_mod (signed) instead of cfg_x_mod. The per-row element count then starts again from cfg_x_count.
- R5: While valid is high and ready is low, addr and valid hold their values.
- R6: In single-shot mode (cfg_auto low at start), the cycle after the cfg_x_count×cfg_y_count-th acceptance shows valid and busy low and done high.
- R7: In circular mode (cfg_auto high at start), the cycle after the final element of a frame shows valid high and addr equal to cfg_start again, and done never rises.
- R8: A start attempt with cfg_x_count zero, cfg_y_count zero, or an odd cfg_x_mod or cfg_y_mod (bit 0 set) raises err and issues no address.
- R9: While done or err is set, en does not start a transfer. A one-cycle pulse on done_clr or err_clr clears the matching flag by the next cycle.
- R10: Dropping en during a transfer makes valid and busy low on the next cycle without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable: starts a transfer from idle, aborts when removed |
| cfg_start | input | AW | Base byte address |
| cfg_x_count | input | CW | Elements per row |
| cfg_x_mod | input | MW | Signed byte stride between elements in a row |
| cfg_y_count | input | CW | Number of rows |
| cfg_y_mod | input | MW | Signed byte stride after the last element of a row |
| cfg_auto | input | 1 | 1 = circular restart, 0 = single shot |
| ready | input | 1 | Sink/source accepts the current address |
| done_clr | input | 1 | Write-one pulse clearing done |
| err_clr | input | 1 | Write-one pulse clearing err |
| addr | output | AW | Current element byte address |
| valid | output | 1 | addr is presented for acceptance |
| busy | output | 1 | A transfer is running |
| done | output | 1 | Sticky single-shot completion flag |
| err | output | 1 | Sticky configuration fault flag |

## Verification
The assertions assume that the configuration inputs change only while the block is idle. This matters because the checks reason from the captured copy. They also assume that a clear pulse is never raised in the same cycle as the event that sets the same flag. The stimulus follows both rules: it loads each configuration at a falling edge before raising en, and it issues clears only after en has been lowered. ready is driven freely and includes alternating stall patterns. The bench asserts it only at falling edges, so the hold check sees clean, stable stalls.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic {ST_IDLE, ST_RUN} dma2d_state_e;
endpackage

// File: rtl/dma2d_cfg_chk.sv
module dma2d_cfg_chk #(
   parameter int CW         = 16,
   parameter int MW         = 16,
   parameter int ELEM_BYTES = 2
) (
   input  logic [CW-1:0]        x_count,
   input  logic [CW-1:0]        y_count,
   input  logic signed [MW-1:0] x_mod,
   input  logic signed [MW-1:0] y_mod,
   output logic                 bad
);
   localparam logic [MW-1:0] ALIGN_MASK = MW'(ELEM_BYTES - 1);

   logic zero_cnt;
   assign zero_cnt = (x_count == '0) || (y_count == '0);

   generate
      if (ELEM_BYTES > 1) begin : g_align
         logic misaligned;
         assign misaligned = ((x_mod & ALIGN_MASK) != '0) || ((y_mod & ALIGN_MASK) != '0);
         assign bad = zero_cnt || misaligned;
      end else begin : g_noalign
         assign bad = zero_cnt;
      end
   endgenerate

   initial begin
      elem_pow2_chk: assert ((ELEM_BYTES & (ELEM_BYTES - 1)) == 0 && ELEM_BYTES >= 1)
         else $error("ELEM_BYTES must be a power of two");
   end
endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          load,
   input  logic          step,
   input  logic [CW-1:0] x_count,
   input  logic [CW-1:0] y_count,
   output logic          row_last,
   output logic          frame_last
);
   logic [CW-1:0] x_rld_q, y_rld_q, x_rem_q, y_rem_q;

   assign row_last   = (x_rem_q == CW'(1));
   assign frame_last = row_last && (y_rem_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_rld_q <= '0;
         y_rld_q <= '0;
         x_rem_q <= '0;
         y_rem_q <= '0;
      end else if (load) begin
         x_rld_q <= x_count;
         y_rld_q <= y_count;
         x_rem_q <= x_count;
         y_rem_q <= y_count;
      end else if (step) begin
         if (row_last) begin
            x_rem_q <= x_rld_q;
            y_rem_q <= (y_rem_q == CW'(1)) ? y_rld_q : y_rem_q - CW'(1);
         end else begin
            x_rem_q <= x_rem_q - CW'(1);
         end
      end
   end

   // R4
   row_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (x_rem_q != '0 && y_rem_q != '0));

   // R4
   row_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && row_last && !load) |=> (x_rem_q == x_rld_q));
endmodule

// File: rtl/dma2d_addr_acc.sv
module dma2d_addr_acc #(
   parameter int AW = 32,
   parameter int MW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic                 use_y,
   input  logic                 wrap,
   input  logic [AW-1:0]        start,
   input  logic signed [MW-1:0] x_mod,
   input  logic signed [MW-1:0] y_mod,
   output logic [AW-1:0]        addr
);
   logic [AW-1:0]        base_q, addr_q;
   logic signed [MW-1:0] xm_q, ym_q, sel_mod;
   logic signed [AW-1:0] stride;

   assign sel_mod = use_y ? ym_q : xm_q;
   assign stride  = AW'(sel_mod);
   assign addr    = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         xm_q   <= '0;
         ym_q   <= '0;
         addr_q <= '0;
      end else if (load) begin
         base_q <= start;
         xm_q   <= x_mod;
         ym_q   <= y_mod;
         addr_q <= start;
      end else if (step) begin
         addr_q <= wrap ? base_q : addr_q + $unsigned(stride);
      end
   end

   // R7
   wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && wrap && !load) |=> (addr_q == base_q));

   initial begin
      width_chk: assert (AW >= MW) else $error("AW must be at least MW");
   end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
   parameter int AW         = 32,
   parameter int CW         = 16,
   parameter int MW         = 16,
   parameter int ELEM_BYTES = 2,
   parameter bit AUTO_EN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [AW-1:0]        cfg_start,
   input  logic [CW-1:0]        cfg_x_count,
   input  logic signed [MW-1:0] cfg_x_mod,
   input  logic [CW-1:0]        cfg_y_count,
   input  logic signed [MW-1:0] cfg_y_mod,
   input  logic                 cfg_auto,
   input  logic                 ready,
   input  logic                 done_clr,
   input  logic                 err_clr,
   output logic [AW-1:0]        addr,
   output logic                 valid,
   output logic                 busy,
   output logic                 done,
   output logic                 err
);
   import dma2d_pkg::*;

   dma2d_state_e state_q;
   logic done_q, err_q, auto_q;
   logic cfg_bad, row_last, frame_last;
   logic start_ok, launch, fault, fire, finish, running;

   assign running  = (state_q == ST_RUN);
   assign start_ok = (state_q == ST_IDLE) && en && !done_q && !err_q;
   assign launch   = start_ok && !cfg_bad;
   assign fault    = start_ok && cfg_bad;
   assign fire     = running && en && ready;
   assign finish   = fire && frame_last && !auto_q;

   assign valid = running;
   assign busy  = running;
   assign done  = done_q;
   assign err   = err_q;

   dma2d_cfg_chk #(.CW(CW), .MW(MW), .ELEM_BYTES(ELEM_BYTES)) cfg_chk_i (
      .x_count (cfg_x_count),
      .y_count (cfg_y_count),
      .x_mod   (cfg_x_mod),
      .y_mod   (cfg_y_mod),
      .bad     (cfg_bad)
   );

   dma2d_walk #(.CW(CW)) walk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (running),
      .load       (launch),
      .step       (fire),
      .x_count    (cfg_x_count),
      .y_count    (cfg_y_count),
      .row_last   (row_last),
      .frame_last (frame_last)
   );

   dma2d_addr_acc #(.AW(AW), .MW(MW)) addr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (launch),
      .step  (fire),
      .use_y (row_last),
      .wrap  (frame_last),
      .start (cfg_start),
      .x_mod (cfg_x_mod),
      .y_mod (cfg_y_mod),
      .addr  (addr)
   );

   generate
      if (AUTO_EN) begin : g_auto
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      auto_q <= 1'b0;
            else if (launch) auto_q <= cfg_auto;
         end
      end else begin : g_noauto
         assign auto_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (launch) state_q <= ST_RUN;
            ST_RUN:  if (!en || finish) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (finish)        done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;
         if (fault)         err_q  <= 1'b1;
         else if (err_clr)  err_q  <= 1'b0;
      end
   end

   // R5
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && en) |=> (valid && $stable(addr)));

   // R6
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(busy) && !busy));

   // R7
   auto_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && auto_q && !done) |=> !done);

   // R8
   err_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !valid);

   // R9
   blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((done || err) && !busy) |=> !busy);

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !en) |=> (!busy && !$rose(done)));

   initial begin
      cnt_width_chk: assert (CW >= 1 && MW >= 2) else $error("bad counter or modify width");
   end
endmodule

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic [31:0]        start;
      logic [15:0]        xc;
      logic signed [15:0] xm;
      logic [15:0]        yc;
      logic signed [15:0] ym;
      logic               stall;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 16'd4, 16'sd2,  16'd3, 16'sd2,  1'b0},
      '{32'h0000_2000, 16'd3, 16'sd2,  16'd2, 16'sd10, 1'b1},
      '{32'h0000_3000, 16'd2, -16'sd2, 16'd3, -16'sd6, 1'b0},
      '{32'h0000_4000, 16'd1, 16'sd2,  16'd4, 16'sd8,  1'b1},
      '{32'h0000_5000, 16'd5, 16'sd4,  16'd1, 16'sd2,  1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b0, cfg_auto = 1'b0, ready = 1'b0, done_clr = 1'b0, err_clr = 1'b0;
   logic [31:0] cfg_start = '0;
   logic [15:0] cfg_x_count = '0, cfg_y_count = '0;
   logic signed [15:0] cfg_x_mod = '0, cfg_y_mod = '0;
   logic [31:0] addr;
   logic valid, busy, done, err;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma2d_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_start(cfg_start),
      .cfg_x_count(cfg_x_count), .cfg_x_mod(cfg_x_mod),
      .cfg_y_count(cfg_y_count), .cfg_y_mod(cfg_y_mod), .cfg_auto(cfg_auto),
      .ready(ready), .done_clr(done_clr), .err_clr(err_clr),
      .addr(addr), .valid(valid), .busy(busy), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(input vec_t v, input int k);
      int xc = int'(v.xc);
      int x = k % xc;
      int y = k / xc;
      longint a = longint'(v.start) + longint'(y) * ((xc - 1) * int'($signed(v.xm)) + int'($signed(v.ym)))
                  + longint'(x) * int'($signed(v.xm));
      return a[31:0];
   endfunction

   task automatic load_cfg(input vec_t v, input logic autom);
      cfg_start = v.start; cfg_x_count = v.xc; cfg_x_mod = v.xm;
      cfg_y_count = v.yc; cfg_y_mod = v.ym; cfg_auto = autom;
   endtask

   task automatic clear_flags();
      en = 1'b0; done_clr = 1'b1; err_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0; err_clr = 1'b0;
      chk(!done && !err, "R9", "flags after clear", {done, err}, 0);
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int total = int'(v.xc) * int'(v.yc);
      int k = 0;
      int cyc = 0;
      load_cfg(v, 1'b0);
      en = 1'b1; ready = 1'b0;
      @(negedge clk);
      chk(valid && busy && addr == v.start, "R2", $sformatf("launch vec %0d", idx), addr, v.start);
      while (k < total && cyc < 500) begin
         // R3 R4 R5: every presented address, including held ones during stalls
         chk(valid && addr == exp_addr(v, k), "R3 R4 R5", $sformatf("vec %0d elem %0d", idx, k),
             addr, exp_addr(v, k));
         ready = v.stall ? logic'(cyc[0]) : 1'b1;
         if (ready) k++;
         cyc++;
         @(negedge clk);
      end
      ready = 1'b0;
      chk(!valid && !busy && done, "R6", $sformatf("vec %0d end", idx), {valid, busy, done}, 3'b001);
      @(negedge clk);
      @(negedge clk);
      chk(!valid && !busy, "R9", "no restart while done set", {valid, busy}, 0);
      clear_flags();
   endtask

   task automatic bad_cfg(input vec_t v, input string what);
      load_cfg(v, 1'b0);
      en = 1'b1; ready = 1'b1;
      @(negedge clk);
      chk(err && !valid, "R8", what, {err, valid}, 2'b10);
      @(negedge clk);
      @(negedge clk);
      chk(!valid && !busy && err, "R9", {what, " blocked"}, {valid, busy}, 0);
      ready = 1'b0;
      clear_flags();
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      vec_t av, bv;
      repeat (3) @(negedge clk);
      chk(!valid && !busy && !done && !err, "R1", "reset state", {valid, busy, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!valid && !busy && !done && !err, "R1", "after reset release", {valid, busy, done, err}, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R7: circular mode wraps with no gap and never sets done
      av = '{32'h0000_0100, 16'd2, 16'sd2, 16'd2, 16'sd6, 1'b0};
      load_cfg(av, 1'b1);
      en = 1'b1; ready = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
         chk(valid && addr == exp_addr(av, k % 4), "R7", $sformatf("circular elem %0d", k),
             addr, exp_addr(av, k % 4));
         chk(!done, "R7", "no done in circular", done, 0);
         @(negedge clk);
      end
      // R10: abort by removing en
      en = 1'b0;
      @(negedge clk);
      chk(!valid && !busy && !done, "R10", "abort circular", {valid, busy, done}, 0);
      ready = 1'b0;

      // R10: abort single shot mid-frame
      load_cfg(VECS[0], 1'b0);
      en = 1'b1; ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(valid && addr == exp_addr(VECS[0], 2), "R3", "before abort", addr, exp_addr(VECS[0], 2));
      en = 1'b0;
      @(negedge clk);
      chk(!valid && !busy && !done, "R10", "abort single", {valid, busy, done}, 0);
      ready = 1'b0;

      // R8: illegal configurations
      bv = '{32'h0000_6000, 16'd0, 16'sd2, 16'd2, 16'sd2, 1'b0};
      bad_cfg(bv, "zero x count");
      bv = '{32'h0000_6000, 16'd2, 16'sd2, 16'd0, 16'sd2, 1'b0};
      bad_cfg(bv, "zero y count");
      bv = '{32'h0000_6000, 16'd2, 16'sd3, 16'd2, 16'sd2, 1'b0};
      bad_cfg(bv, "odd x modify");
      bv = '{32'h0000_6000, 16'd2, 16'sd2, 16'd2, -16'sd5, 1'b0};
      bad_cfg(bv, "odd y modify");

      // R9: a legal run works again after the clears
      run_vec(VECS[4], 9);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule